// File: doc/BRIEF.md
# Synchronous Burst Cache Data Store

A single-ported synchronous static RAM that serves as the data array of a second-level cache. It has a built-in four-beat burst address generator. A burst starts when one of two active-low address strobes is sampled low on a rising clock edge. The processor-side strobe has priority. It always starts a read. The controller-side strobe starts a read or a write, depending on the byte write enables. After the first beat, a burst-advance input either steps to the next beat or repeats the current one, which inserts a wait state. The beat order is interleaved: the two low address bits of beat n are the base low bits XOR n. The upper bits stay fixed, and the sequence wraps after four beats.

Each word is split into byte lanes of nine bits each: eight data bits and one parity bit. The parity bit is stored as plain data. Each lane has its own active-low write enable. Writes commit on the clock edge. Read data is flow-through: the word at the current beat address appears in the cycle after the edge that selected it. An asynchronous output enable gates the read path. The tri-state pad is represented by a data output together with an output-valid flag, and the data output is zero whenever the flag is low.

Chip enable is sampled only on edges that load a new base address. A load with chip enable high deselects the device until the next successful load.

Top module: `burst_sram_core`

## Requirements
- R1: Synchronous active-low reset leaves the device deselected with the output disabled. Memory contents survive reset, and a continuation cycle after reset writes nothing.
- R2: With `adsp_n` low and `ce_n` low at an edge, a read burst starts at `addr`. In that cycle `adsc_n` and `bwe_n` have no effect, and the stored word is presented in the following cycle.
- R3: With `adsp_n` high, `adsc_n` low and `ce_n` low, a burst starts at `addr`. The first beat is a write at `addr` if any `bwe_n` bit is low, and a read otherwise.
- R4: A processor-strobe write takes two cycles. The first cycle loads the address with `adsp_n` low. In the second cycle both strobes are high, `adv_n` is high and the byte enables are low, and the data is written at the loaded address.
- R5: `ce_n` is sampled only when a strobe is low. If `ce_n` is high then, the device is deselected: the output stays disabled and continuation cycles neither read nor write. `ce_n` is ignored in continuation cycles of an active burst.
- R6: With both strobes high and `adv_n` low, the beat counter advances before the access. The beat n address is `{base[ADDR_W-1:2], base[1:0] ^ n}`, and beat 4 wraps to the base address.
- R7: With both strobes high and `adv_n` high, the access repeats the current address. A read keeps its output stable, and a write overwrites the same word.
- R8: Byte lane k (bits `9k+8..9k`) is written only when `bwe_n[k]` is 0. All other lanes of the word keep their old value.
- R9: `dout_en` is 1 only when the device is selected, the last access was a read, and `oe_n` is 0. When `dout_en` is 1, `dout` equals the stored word at the current beat address. Otherwise `dout` is 0.
- R10: A strobe that loads a new base address abandons any burst in progress and restarts the beat count at zero, even when that burst is a write burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External base word address |
| adsp_n | input | 1 | Processor-side address strobe, active low, highest priority |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait state |
| ce_n | input | 1 | Chip enable, active low, sampled on base loads only |
| bwe_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Read path drives `dout` |

## Verification
A wrong beat counter or base register shows up at the ports in the very next cycle: the word read back belongs to another beat, or the burst fails to return to its base word on the fifth beat. Stale selection or write-flag state shows up one edge after a load, as an output that turns on during a write, stays on after a deselecting load, or stays off when it should drive. A write sent to the wrong lane or address stays hidden until that word is read again. The bench therefore follows every write burst with a read burst over the same words and compares each cycle against a behavioural model.

// File: rtl/bsr_pkg.sv
// Package: shared types and helpers for the burst cache data store.
// Assumes a fixed four-beat burst with interleaved beat ordering.
package bsr_pkg;

    // What a rising edge does to the burst state.
    typedef enum logic [2:0] {
        ACT_IDLE,   // no strobe, no active burst: nothing happens
        ACT_DESEL,  // a strobe seen with chip enable high
        ACT_LOAD,   // a strobe loads a new base address
        ACT_STEP,   // continuation, advance one beat
        ACT_HOLD    // continuation, repeat current beat (wait state)
    } act_e;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    // Low address bits of a given beat under interleaved ordering.
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] base_lo,
        input logic [BEAT_W-1:0] beat
    );
        return base_lo ^ beat;
    endfunction

endpackage

// File: rtl/bsr_decode.sv
// Module: bsr_decode
// Turns the strobe, advance and enable pins of one cycle into the action
// taken at the next edge, and the per-lane write strobes for that edge.
// Assumes: processor strobe outranks controller strobe; chip enable is only
// meaningful when a strobe is low; continuation needs an active burst.
module bsr_decode
    import bsr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce_n,
    input  logic [LANES-1:0] bwe_n,
    input  logic             active,
    output act_e             act,
    output logic             wr_req,
    output logic [LANES-1:0] lane_we
);

    logic any_lane;

    // Any lane asking for a write this cycle.
    assign any_lane = ~&bwe_n;

    // Priority decode of the edge action and of whether it writes.
    always_comb begin
        act    = ACT_IDLE;
        wr_req = 1'b0;
        if (!adsp_n) begin
            act    = ce_n ? ACT_DESEL : ACT_LOAD;
            wr_req = 1'b0;
        end else if (!adsc_n) begin
            act    = ce_n ? ACT_DESEL : ACT_LOAD;
            wr_req = !ce_n && any_lane;
        end else if (active) begin
            act    = adv_n ? ACT_HOLD : ACT_STEP;
            wr_req = any_lane;
        end
    end

    // Lane strobes follow the pins only when the edge really writes.
    assign lane_we = wr_req ? ~bwe_n : '0;

endmodule

// File: rtl/bsr_burst_seq.sv
// Module: bsr_burst_seq
// Holds the burst state: base address, beat counter, selection and the
// read/write kind of the last access. Produces the address used at the
// coming edge and the address of the beat now current.
// Assumes ADDR_W >= 3 so that upper and beat bits both exist.
module bsr_burst_seq
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              active,
    output logic              wr_flag
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] cnt_inc;
    logic [HI_W-1:0]   base_hi;

    assign base_hi = base_q[ADDR_W-1:BEAT_W];
    assign cnt_inc = cnt_q + 1'b1;

    // Address of the beat that the last edge selected.
    assign cur_addr = {base_hi, beat_low(base_q[BEAT_W-1:0], cnt_q)};

    // Address the coming edge accesses (advance happens before access).
    always_comb begin
        case (act)
            ACT_LOAD: acc_addr = addr;
            ACT_STEP: acc_addr = {base_hi, beat_low(base_q[BEAT_W-1:0], cnt_inc)};
            default:  acc_addr = cur_addr;
        endcase
    end

    // Burst state update per edge action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            cnt_q   <= '0;
            active  <= 1'b0;
            wr_flag <= 1'b0;
        end else begin
            case (act)
                ACT_DESEL: begin
                    active  <= 1'b0;
                    wr_flag <= 1'b0;
                end
                ACT_LOAD: begin
                    base_q  <= addr;
                    cnt_q   <= '0;
                    active  <= 1'b1;
                    wr_flag <= wr_req;
                end
                ACT_STEP: begin
                    cnt_q   <= cnt_inc;
                    wr_flag <= wr_req;
                end
                ACT_HOLD: begin
                    wr_flag <= wr_req;
                end
                default: begin
                    wr_flag <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bsr_lane_array.sv
// Module: bsr_lane_array
// Storage split into independent byte lanes, each with its own write
// strobe. Write on the rising edge, read combinationally (flow-through).
// Assumes contents are not reset; parity bits are stored as plain data.
module bsr_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        // Commit this lane's slice when its strobe is set.
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                store[wr_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = store[rd_addr];
    end

endmodule

// File: rtl/bsr_out_drv.sv
// Module: bsr_out_drv
// Models the tri-state read pad as data plus a drive flag. Drives only for
// a selected device whose last access was a read and whose output enable
// is low; forces the data to zero otherwise.
module bsr_out_drv #(
    parameter int DW = 36
) (
    input  logic          active,
    input  logic          wr_flag,
    input  logic          oe_n,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    // Asynchronous enable gating.
    assign dout_en = active && !wr_flag && !oe_n;
    assign dout    = dout_en ? rdata : '0;

endmodule

// File: rtl/burst_sram_core.sv
// Module: burst_sram_core
// Synchronous burst data store with a four-beat interleaved address
// generator, two address strobes, per-lane writes and a gated read path.
// Assumes all inputs except oe_n are sampled on the rising clock edge.
module burst_sram_core
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    ce_n,
    input  logic [LANES-1:0]        bwe_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DW = LANES * LANE_W;

    act_e              act;
    logic              wr_req;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic              active;
    logic              wr_flag;
    logic [DW-1:0]     rdata;

    bsr_decode #(.LANES(LANES)) u_decode (
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .adv_n   (adv_n),
        .ce_n    (ce_n),
        .bwe_n   (bwe_n),
        .active  (active),
        .act     (act),
        .wr_req  (wr_req),
        .lane_we (lane_we)
    );

    bsr_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .wr_req   (wr_req),
        .addr     (addr),
        .acc_addr (acc_addr),
        .cur_addr (cur_addr),
        .active   (active),
        .wr_flag  (wr_flag)
    );

    bsr_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .lane_we (lane_we),
        .wr_addr (acc_addr),
        .wdata   (din),
        .rd_addr (cur_addr),
        .rdata   (rdata)
    );

    bsr_out_drv #(.DW(DW)) u_out (
        .active  (active),
        .wr_flag (wr_flag),
        .oe_n    (oe_n),
        .rdata   (rdata),
        .dout    (dout),
        .dout_en (dout_en)
    );

endmodule

// File: rtl/bsr_checker.sv
// Module: bsr_checker
// Protocol properties of the burst data store, attached by bind. Observes
// ports plus the selection flag and current beat address of the sequencer.
module bsr_checker #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       addr,
    input logic                    adsp_n,
    input logic                    adsc_n,
    input logic                    adv_n,
    input logic                    ce_n,
    input logic [LANES-1:0]        bwe_n,
    input logic                    oe_n,
    input logic [LANES*LANE_W-1:0] dout,
    input logic                    dout_en,
    input logic                    active,
    input logic [ADDR_W-1:0]       cur_addr
);

    // R2: a processor-strobe load is a read, driven iff output enable is low.
    p_adsp_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n) |=> (dout_en == !oe_n));

    // R10: any successful load restarts at the external address.
    p_load_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((!adsp_n || !adsc_n) && !ce_n) |=> (cur_addr == $past(addr)));

    // R3: a controller-strobe write load never drives the output.
    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && !adsc_n && !ce_n && !(&bwe_n)) |=> !dout_en);

    // R5: a load with chip enable high deselects.
    p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((!adsp_n || !adsc_n) && ce_n) |=> (!active && !dout_en));

    // R5: without a strobe a deselected device stays deselected.
    p_idle_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && adsp_n && adsc_n) |=> !active);

    // R6: an advance keeps the upper bits and moves the beat bits.
    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && adsp_n && adsc_n && !adv_n) |=>
        (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])) &&
        (cur_addr[1:0] != $past(cur_addr[1:0])));

    // R7: a suspended read keeps the driven data stable.
    p_suspend_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n && adv_n && (&bwe_n) && dout_en) |=>
        (oe_n || $stable(dout)));

    // R9: nothing is driven while output enable is high.
    p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dout_en && dout == '0));

endmodule

bind burst_sram_core bsr_checker #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .adv_n    (adv_n),
    .ce_n     (ce_n),
    .bwe_n    (bwe_n),
    .oe_n     (oe_n),
    .dout     (dout),
    .dout_en  (dout_en),
    .active   (active),
    .cur_addr (cur_addr)
);

// File: tb/sim_burst_sram_core.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, compared every
// cycle with a behavioural model built from the requirements.
module sim_burst_sram_core;

    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [AW-1:0]    addr;
    logic             adsp_n, adsc_n, adv_n, ce_n, oe_n;
    logic [LANES-1:0] bwe_n;
    logic [DW-1:0]    din;
    logic [DW-1:0]    dout;
    logic             dout_en;

    int checks = 0;
    int fails  = 0;

    // Behavioural model state.
    logic [DW-1:0] m_mem [DEPTH];
    logic          m_act;
    logic          m_wr;
    logic [AW-1:0] m_base;
    logic [1:0]    m_n;

    // Scratch values for directed tests.
    logic [DW-1:0] v0, v1, v2, v3;
    logic [AW-1:0] ta, tb_b, tc;

    always #4 clk = ~clk;

    burst_sram_core #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n),
        .adsc_n(adsc_n), .adv_n(adv_n), .ce_n(ce_n), .bwe_n(bwe_n),
        .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [AW-1:0] m_cur();
        return {m_base[AW-1:2], m_base[1:0] ^ m_n};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [LANES-1:0] en_n);
        logic [DW-1:0] r;
        r = old_w;
        for (int k = 0; k < LANES; k++)
            if (!en_n[k]) r[k*LW +: LW] = new_w[k*LW +: LW];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int s, input int n);
        return DW'(64'h0F1E_2D3C_4B5A_6978 ^ (64'(s * 4 + n + 1) * 64'h0000_0009_E377_9B97));
    endfunction

    // Apply one edge to the model.
    task automatic model_edge();
        logic [AW-1:0] a;
        if (!adsp_n) begin
            if (ce_n) m_act = 1'b0;
            else begin m_act = 1'b1; m_base = addr; m_n = 2'd0; end
            m_wr = 1'b0;
        end else if (!adsc_n) begin
            if (ce_n) begin m_act = 1'b0; m_wr = 1'b0; end
            else begin
                m_act = 1'b1; m_base = addr; m_n = 2'd0;
                m_wr = !(&bwe_n);
                m_mem[addr] = merge(m_mem[addr], din, bwe_n);
            end
        end else if (m_act) begin
            if (!adv_n) m_n = m_n + 2'd1;
            a = m_cur();
            m_wr = !(&bwe_n);
            m_mem[a] = merge(m_mem[a], din, bwe_n);
        end else begin
            m_wr = 1'b0;
        end
    endtask

    // One cycle: drive, clock, model, then compare at the falling edge.
    task automatic cyc(input logic p, input logic c, input logic v,
                       input logic e, input logic [LANES-1:0] w,
                       input logic o, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
        logic          exp_en;
        logic [DW-1:0] exp_d;
        adsp_n = p; adsc_n = c; adv_n = v; ce_n = e;
        bwe_n = w; oe_n = o; addr = a; din = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_en = m_act && !m_wr && !oe_n;
        exp_d  = exp_en ? m_mem[m_cur()] : '0;
        checks++;
        if (dout_en !== exp_en || dout !== exp_d) begin
            fails++;
            $display("FAIL %s model: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     tag, dout_en, dout, exp_en, exp_d);
        end
    endtask

    task automatic ld_p(input logic [AW-1:0] a, input string tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, '1, 1'b0, a, '0, tag);
    endtask

    task automatic ld_c(input logic [AW-1:0] a, input logic [LANES-1:0] w,
                        input logic [DW-1:0] d, input string tag);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, w, 1'b0, a, d, tag);
    endtask

    task automatic go(input logic v, input logic [LANES-1:0] w,
                      input logic [DW-1:0] d, input string tag);
        cyc(1'b1, 1'b1, v, 1'b0, w, 1'b0, '0, d, tag);
    endtask

    task automatic expect_q(input string tag, input logic [DW-1:0] exp);
        checks++;
        if (dout_en !== 1'b1 || dout !== exp) begin
            fails++;
            $display("FAIL %s data: dout_en=%0b dout=%h expected dout_en=1 dout=%h",
                     tag, dout_en, dout, exp);
        end
    endtask

    task automatic expect_off(input string tag);
        checks++;
        if (dout_en !== 1'b0 || dout !== '0) begin
            fails++;
            $display("FAIL %s off: dout_en=%0b dout=%h expected dout_en=0 dout=0",
                     tag, dout_en, dout);
        end
    endtask

    task automatic do_reset();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; ce_n = 1'b1;
        bwe_n = '1; oe_n = 1'b0; addr = '0; din = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        m_act = 1'b0; m_wr = 1'b0; m_n = 2'd0; m_base = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog R1..R10 run: actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        do_reset();
        expect_off("R1");

        // Fill every word through controller-strobe write bursts (R3, R6).
        for (int b = 0; b < DEPTH / 4; b++) begin
            ld_c(AW'(b * 4), '0, DW'({$urandom, $urandom}), "R3");
            for (int n = 1; n < 4; n++) go(1'b0, '0, DW'({$urandom, $urandom}), "R6");
        end

        // R1: reset keeps memory; continuation after reset writes nothing.
        ta = 6'h05; v0 = m_mem[ta];
        do_reset();
        expect_off("R1");
        go(1'b0, '0, pat(9, 9), "R1");
        expect_off("R1");
        ld_p(ta, "R1");
        expect_q("R1", v0);

        // R2: processor strobe ignores controller strobe and byte enables.
        ta = 6'h09; v0 = m_mem[ta];
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, ta, pat(7, 1), "R2");
        expect_q("R2", v0);

        // R4: second cycle of a processor-strobe write commits the data.
        cyc(1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0, 6'h3F, pat(7, 2), "R4");
        expect_off("R9");
        ld_p(ta, "R4");
        expect_q("R4", pat(7, 2));

        // R5: deselecting load, then continuation does nothing.
        ta = 6'h20; v0 = m_mem[ta]; v1 = m_mem[ta ^ 6'd1];
        cyc(1'b1, 1'b0, 1'b1, 1'b1, '0, 1'b0, ta, pat(8, 0), "R5");
        expect_off("R5");
        go(1'b0, '0, pat(8, 1), "R5");
        expect_off("R5");
        ld_p(ta, "R5");
        expect_q("R5", v0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, '1, 1'b0, '0, '0, "R5");
        expect_q("R5", v1);

        // R6: write then read bursts from every low-address start, with wrap.
        for (int s = 0; s < 4; s++) begin
            ta = AW'((s + 3) * 4 + s);
            ld_c(ta, '0, pat(s, 0), "R6");
            for (int n = 1; n < 4; n++) go(1'b0, '0, pat(s, n), "R6");
            ld_p(ta, "R6");
            expect_q("R6", pat(s, 0));
            for (int m = 1; m <= 4; m++) begin
                go(1'b0, '1, '0, "R6");
                expect_q("R6", pat(s, m % 4));
            end
        end

        // R7: suspended write overwrites the same word; suspended read holds.
        tb_b = 6'h2C;
        ld_c(tb_b, '0, pat(5, 0), "R7");
        go(1'b1, '0, pat(5, 1), "R7");
        go(1'b0, '0, pat(5, 2), "R7");
        ld_p(tb_b, "R7");
        expect_q("R7", pat(5, 1));
        go(1'b1, '1, '0, "R7");
        expect_q("R7", pat(5, 1));
        go(1'b0, '1, '0, "R7");
        expect_q("R7", pat(5, 2));

        // R8: partial lane write; lanes 0 and 2 enabled (bwe_n = 1010).
        ta = 6'h33; v0 = pat(6, 0); v1 = pat(6, 1);
        ld_c(ta, '0, v0, "R8");
        ld_c(ta, 4'b1010, v1, "R8");
        ld_p(ta, "R8");
        v2 = v0;
        v2[0*LW +: LW] = v1[0*LW +: LW];
        v2[2*LW +: LW] = v1[2*LW +: LW];
        expect_q("R8", v2);

        // R10: processor strobe cuts a write burst short.
        tb_b = 6'h10; tc = 6'h18;
        v0 = m_mem[tb_b ^ 6'd2]; v1 = m_mem[tc]; v3 = m_mem[tc ^ 6'd1];
        ld_c(tb_b, '0, pat(4, 0), "R10");
        go(1'b0, '0, pat(4, 1), "R10");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, tc, pat(4, 2), "R10");
        expect_q("R10", v1);
        go(1'b0, '1, '0, "R10");
        expect_q("R10", v3);
        ld_p(tb_b ^ 6'd2, "R10");
        expect_q("R10", v0);

        // R9: output enable high blanks a read.
        cyc(1'b0, 1'b1, 1'b1, 1'b0, '1, 1'b1, 6'h01, '0, "R9");
        expect_off("R9");

        // Random traffic against the model.
        for (int i = 0; i < 3000; i++) begin
            logic [LANES-1:0] w;
            w = (($urandom % 2) == 0) ? '1 : LANES'($urandom);
            cyc((($urandom % 100) < 15) ? 1'b0 : 1'b1,
                (($urandom % 100) < 20) ? 1'b0 : 1'b1,
                1'($urandom % 2),
                (($urandom % 100) < 85) ? 1'b0 : 1'b1,
                w,
                (($urandom % 100) < 80) ? 1'b0 : 1'b1,
                AW'($urandom), DW'({$urandom, $urandom}), "R9");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule